// File: doc/BRIEF.md
# Iterative Shift-Add Multiplier Engine

This block multiplies two unsigned operands in a fixed number of clock cycles. It uses a small datapath with a tiny control unit beside it. The datapath holds three equal-width registers: a multiplicand, an accumulator and a multiplier. The accumulator and the multiplier together act as one double-width pair. Each register can be written from a shared parallel input under its own load strobe. The block accepts these writes only while it is idle.

A start pulse sets the `busy` flag. The control unit then issues exactly WIDTH step cycles. On each step, the low bit of the multiplier register decides whether the multiplicand is added into the accumulator. The whole pair, including the carry from that add, shifts right by one in the same cycle. When `busy` drops, the pair holds `mcand * mplier_initial + acc_initial`. The high half is in the accumulator and the low half is in the multiplier register. A caller clears the accumulator before starting to get a plain product.

The operands arrive on individual strobes and status is a single level. For that reason the edge of the block uses plain control pins and no handshake. The caller polls `busy`, or waits WIDTH+1 cycles after start, before it reads the result.

Top module: `shiftmul_engine`

## Requirements
- R1: A synchronous active-high `rst` clears `mcand_q`, `acc_q`, `mplier_q` and `busy` on the next clock edge.
- R2: While `busy` is 0, a clock edge with `ld_mcand`, `ld_acc` or `ld_mplier` high copies `din` into that register only. A register whose strobe is low keeps its value.
- R3: While `busy` is 0, a clock edge with `start` high sets `busy` to 1 on that edge.
- R4: Once set, `busy` stays 1 for exactly WIDTH clock cycles and then returns to 0.
- R5: When `busy` returns to 0, the concatenation {`acc_q`, `mplier_q`} equals `mcand_q * M + A`. Here M and A are the multiplier and accumulator values held when `start` was accepted, and the arithmetic is unsigned, 2*WIDTH bits, with no lost carry.
- R6: `mcand_q` does not change while `busy` is 1.
- R7: A `start` pulse while `busy` is 1 is ignored. The run length and the result are unchanged.
- R8: Load strobes while `busy` is 1 are ignored and do not disturb the result.
- R9: Loads and `start` in the same idle cycle both take effect, and the run uses the newly loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | WIDTH | Parallel load data |
| ld_mcand | input | 1 | Load multiplicand from `din` |
| ld_acc | input | 1 | Load accumulator from `din` |
| ld_mplier | input | 1 | Load multiplier from `din` |
| start | input | 1 | Launch a multiply (one-cycle pulse) |
| busy | output | 1 | 1 while step cycles are in progress |
| mcand_q | output | WIDTH | Multiplicand register |
| acc_q | output | WIDTH | Accumulator (high half of result) |
| mplier_q | output | WIDTH | Multiplier register (low half of result) |

## Verification
The bound checker watches the following on every cycle:
- Idle registers hold or load exactly as their strobes say.
- `start` raises `busy` when the block is idle.
- The multiplicand is frozen during a run.
- An independent counter shows each run lasts WIDTH cycles, whatever else is driven.

Only the bench's scenarios can show the arithmetic outcome. They sweep every operand pair of a small configuration with varied starting accumulator values, and disturb some runs with stray starts and loads. They also combine loads with start in one cycle and apply reset in the middle of a run.

// File: rtl/shiftmul_pkg.sv
package shiftmul_pkg;
  typedef enum logic {
    CU_IDLE = 1'b0,
    CU_STEP = 1'b1
  } cu_state_e;
endpackage

// File: rtl/shiftmul_ctrl.sv
module shiftmul_ctrl
  import shiftmul_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic step
);
  localparam int CW = $clog2(WIDTH) + 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  cu_state_e     state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CU_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        CU_IDLE: begin
          if (start) begin
            state <= CU_STEP;
            cnt   <= '0;
          end
        end
        CU_STEP: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= CU_IDLE;
        end
        default: state <= CU_IDLE;
      endcase
    end
  end

  assign step = (state == CU_STEP);
endmodule

// File: rtl/shiftmul_dpath.sv
module shiftmul_dpath #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [WIDTH-1:0] din,
  input  logic             ld_mcand,
  input  logic             ld_acc,
  input  logic             ld_mplier,
  output logic [WIDTH-1:0] mcand,
  output logic [WIDTH-1:0] acc,
  output logic [WIDTH-1:0] mplier
);
  logic [WIDTH:0] addend;
  logic [WIDTH:0] sum;

  // Low multiplier bit selects add-or-skip directly in the datapath
  always_comb begin
    addend = mplier[0] ? {1'b0, mcand} : '0;
    sum    = {1'b0, acc} + addend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand  <= '0;
      acc    <= '0;
      mplier <= '0;
    end else if (step) begin
      acc    <= sum[WIDTH:1];
      mplier <= {sum[0], mplier[WIDTH-1:1]};
    end else begin
      if (ld_mcand)  mcand  <= din;
      if (ld_acc)    acc    <= din;
      if (ld_mplier) mplier <= din;
    end
  end
endmodule

// File: rtl/shiftmul_engine.sv
module shiftmul_engine #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic             ld_mcand,
  input  logic             ld_acc,
  input  logic             ld_mplier,
  input  logic             start,
  output logic             busy,
  output logic [WIDTH-1:0] mcand_q,
  output logic [WIDTH-1:0] acc_q,
  output logic [WIDTH-1:0] mplier_q
);
  logic step;

  shiftmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .step  (step)
  );

  shiftmul_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .din       (din),
    .ld_mcand  (ld_mcand),
    .ld_acc    (ld_acc),
    .ld_mplier (ld_mplier),
    .mcand     (mcand_q),
    .acc       (acc_q),
    .mplier    (mplier_q)
  );

  assign busy = step;
endmodule

// File: rtl/shiftmul_chk.sv
module shiftmul_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] din,
  input logic             ld_mcand,
  input logic             ld_acc,
  input logic             ld_mplier,
  input logic             start,
  input logic             busy,
  input logic [WIDTH-1:0] mcand_q,
  input logic [WIDTH-1:0] acc_q,
  input logic [WIDTH-1:0] mplier_q
);
  localparam int KW = $clog2(WIDTH) + 2;
  localparam logic [KW-1:0] RUNLEN = KW'(WIDTH);

  logic [KW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= '0;
    else              busy_len <= busy_len + 1'b1;
  end

  // R3
  start_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  // R4
  run_len_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(busy)) |-> (busy_len == RUNLEN));

  // R4
  run_len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_len < RUNLEN));

  // R6
  mcand_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mcand_q));

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ld_acc) |=> $stable(acc_q));

  // R2
  mplier_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ld_mplier) |=> $stable(mplier_q));

  // R2
  mcand_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ld_mcand) |=> $stable(mcand_q));

  // R2
  acc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && ld_acc) |=> (acc_q == $past(din)));
endmodule

bind shiftmul_engine shiftmul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .din       (din),
  .ld_mcand  (ld_mcand),
  .ld_acc    (ld_acc),
  .ld_mplier (ld_mplier),
  .start     (start),
  .busy      (busy),
  .mcand_q   (mcand_q),
  .acc_q     (acc_q),
  .mplier_q  (mplier_q)
);

// File: tb/tb_shiftmul_engine.sv
`timescale 1ns/1ps
module tb_shiftmul_engine;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 0;
  logic         rst = 1;
  logic [W-1:0] din = '0;
  logic         ld_mcand = 0, ld_acc = 0, ld_mplier = 0, start = 0;
  logic         busy;
  logic [W-1:0] mcand_q, acc_q, mplier_q;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  shiftmul_engine #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .din(din),
    .ld_mcand(ld_mcand), .ld_acc(ld_acc), .ld_mplier(ld_mplier),
    .start(start), .busy(busy),
    .mcand_q(mcand_q), .acc_q(acc_q), .mplier_q(mplier_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load1(input int which, input int val);
    din = W'(val);
    ld_mcand  = (which == 0);
    ld_acc    = (which == 1);
    ld_mplier = (which == 2);
    tick();
    ld_mcand = 0; ld_acc = 0; ld_mplier = 0;
  endtask

  // Runs one multiply; optionally disturbs it with start and loads mid-run
  task automatic run_mul(input int ic, input int a0, input int b, input bit disturb, input bit fused);
    int len;
    load1(0, ic);
    load1(1, a0);
    if (fused) begin
      din = W'(b); ld_mplier = 1; start = 1;  // R9
    end else begin
      load1(2, b);
      chk("R2", {mcand_q, acc_q, mplier_q}, (ic << (2*W)) | (a0 << W) | b);
      start = 1;
    end
    tick();
    start = 0; ld_mplier = 0;
    len = 0;
    while (busy && len < 3*W) begin
      if (disturb && len == 1) begin
        din = ~W'(b); start = 1; ld_mcand = 1; ld_acc = 1; ld_mplier = 1;
      end
      tick();
      start = 0; ld_mcand = 0; ld_acc = 0; ld_mplier = 0;
      len++;
      if (disturb && len == 2) chk("R6", mcand_q, ic);
    end
    chk(disturb ? "R7" : "R4", len, W);
    chk(disturb ? "R8" : (fused ? "R9" : "R5"), {acc_q, mplier_q}, ic * b + a0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    tick(); tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1", {busy, mcand_q, acc_q, mplier_q}, 0);

    // R3: start visible as busy on the next edge
    start = 1; tick(); start = 0;
    chk("R3", busy, 1);
    repeat (W) tick();
    chk("R4", busy, 0);

    for (int ic = 0; ic < N; ic++) begin
      for (int b = 0; b < N; b++) begin
        run_mul(ic, (ic * 3 + b) % N, b, ((ic + b) % 5) == 0, 1'b0);
      end
    end

    // R9 fused load-and-start, plain product case
    run_mul(N - 1, 0, N - 1, 1'b0, 1'b1);
    run_mul(5, 7, 9 % N, 1'b0, 1'b1);

    // R1 reset during a run
    load1(0, N - 1); load1(2, N - 1);
    start = 1; tick(); start = 0; tick();
    rst = 1; tick(); rst = 0;
    chk("R1", {busy, mcand_q, acc_q, mplier_q}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule